// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block sits beside a small 8-bit processor core and chooses which of up to eight interrupt request lines the core should service next. A request is eligible only when the global enable and the enable of its own source are both set. Every source carries a one-bit priority: high or low. When the core signals that its current instruction has completed, the controller can issue a single-cycle take strobe. In that same cycle it presents the fixed entry address of the winning source and a one-hot acknowledge to that source.

The controller holds one in-service bit per priority level. A running low-level handler can be interrupted only by a high-level request. Nothing interrupts a running high-level handler. A return strobe from the core retires the highest active level. At least one further instruction must then complete before a new take is allowed. Two of the sources each merge a pair of request flags, so each of them has one entry address shared by two causes.

Top module: `vec_irq_ctrl`

## Requirements
- R1: While `rst_n` is low, `take` stays 0 and `ack` and `vec_addr` stay all-zero, whatever the inputs are. After reset neither level is in service.
- R2: A source can win only when `glob_en` is 1 and its `src_en` bit is 1. Otherwise its request causes no take.
- R3: `take` is 1 only in a cycle where `insn_done` is 1. It is evaluated in that same cycle, with no register delay.
- R4: In the take cycle, `vec_addr` equals 0x0003 + 8 × index of the winning source (0x0003 for source 0 up to 0x003B for source 7). Outside a take cycle it is 0x0000.
- R5: When several eligible requests share a priority level, the lowest-numbered source wins.
- R6: An eligible request whose `src_hi` bit is 1 wins over any eligible request whose `src_hi` bit is 0, whatever the source numbers.
- R7: While a low-level handler is in service, only a high-level request can be taken. While a high-level handler is in service, no request is taken.
- R8: Source 5 is requested by `irq_req[5]` OR `irq_req_alt[5]`, and source 6 by `irq_req[6]` OR `irq_req_alt[6]`. `irq_req_alt` bits of every other source have no effect.
- R9: A `reti` pulse clears the high in-service level if it is set, and otherwise clears the low level. A low level underneath is kept.
- R10: No take occurs in a cycle with `reti` high, nor at the first `insn_done` after a `reti`. A take becomes possible again at the `insn_done` after that.
- R11: `ack` is one-hot with bit i set for winning source i in the take cycle, and all-zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 8 | Primary request flag per source |
| irq_req_alt | input | 8 | Second request flag, honoured for sources 5 and 6 only |
| glob_en | input | 1 | Global interrupt enable |
| src_en | input | 8 | Per-source enable |
| src_hi | input | 8 | Per-source priority, 1 = high level |
| insn_done | input | 1 | Current instruction completes this cycle |
| reti | input | 1 | Return-from-interrupt strobe |
| take | output | 1 | Single-cycle take strobe |
| vec_addr | output | 16 | Entry address of the winner, valid with take |
| ack | output | 8 | One-hot acknowledge to the winner, valid with take |

## Verification
A corrupted in-service bit shows up at the very next `insn_done` as a wrong outcome at the ports. A take appears that should have been held back, or a pending request is stuck silent. The scenarios therefore return repeatedly through `reti` and probe the next instruction completion, including a return that must leave the low level active. A wrong post-return hold appears at once as an early or missing take, one instruction after the return. Priority and polling faults show up in the same cycle as a wrong `vec_addr` and `ack` pair.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

   typedef enum logic {
      LVL_LO = 1'b0,
      LVL_HI = 1'b1
   } lvl_e;

   typedef struct packed {
      logic hi;
      logic lo;
   } isv_t;

   // Entry address of a source: base plus index scaled by a power-of-two stride.
   function automatic logic [31:0] entry_of(input logic [31:0] base,
                                            input logic [31:0] idx,
                                            input int unsigned shift);
      return base + (idx << shift);
   endfunction

endpackage

// File: rtl/irq_src_cond.sv
module irq_src_cond #(
   parameter int unsigned         NUM_SRC   = 8,
   parameter logic [NUM_SRC-1:0]  DUAL_MASK = 8'h60
) (
   input  logic [NUM_SRC-1:0] irq_req,
   input  logic [NUM_SRC-1:0] irq_req_alt,
   input  logic               glob_en,
   input  logic [NUM_SRC-1:0] src_en,
   input  logic [NUM_SRC-1:0] src_hi,
   output logic [NUM_SRC-1:0] cand_hi,
   output logic [NUM_SRC-1:0] cand_lo
);

   logic [NUM_SRC-1:0] merged;
   logic [NUM_SRC-1:0] eligible;
   logic               unused_alt;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      if (DUAL_MASK[i]) begin : g_dual
         assign merged[i] = irq_req[i] | irq_req_alt[i];
      end else begin : g_single
         assign merged[i] = irq_req[i];
      end
   end

   assign unused_alt = ^(irq_req_alt & ~DUAL_MASK);

   assign eligible = merged & src_en & {NUM_SRC{glob_en}};
   assign cand_hi  = eligible & src_hi;
   assign cand_lo  = eligible & ~src_hi;

endmodule

// File: rtl/irq_first_pick.sv
module irq_first_pick #(
   parameter int unsigned NUM_SRC = 8,
   localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
   input  logic [NUM_SRC-1:0] cand,
   output logic               any,
   output logic [IDX_W-1:0]   idx,
   output logic [NUM_SRC-1:0] onehot
);

   // Fixed polling order: the lowest index has precedence.
   always_comb begin
      idx = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (cand[i]) begin
            idx = IDX_W'(i);
         end
      end
   end

   assign any    = |cand;
   assign onehot = cand & ~(cand - NUM_SRC'(1));

endmodule

// File: rtl/irq_level_track.sv
module irq_level_track
   import irq_ctrl_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic take,
   input  lvl_e take_lvl,
   input  logic reti,
   input  logic insn_done,
   output logic isv_hi,
   output logic isv_lo,
   output logic hold
);

   isv_t isv_q;
   logic hold_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         isv_q  <= '0;
         hold_q <= 1'b0;
      end else begin
         if (reti) begin
            if (isv_q.hi) begin
               isv_q.hi <= 1'b0;
            end else begin
               isv_q.lo <= 1'b0;
            end
         end else if (take) begin
            if (take_lvl == LVL_HI) begin
               isv_q.hi <= 1'b1;
            end else begin
               isv_q.lo <= 1'b1;
            end
         end
         if (reti) begin
            hold_q <= 1'b1;
         end else if (insn_done) begin
            hold_q <= 1'b0;
         end
      end
   end

   assign isv_hi = isv_q.hi;
   assign isv_lo = isv_q.lo;
   assign hold   = hold_q;

endmodule

// File: rtl/irq_vec_gen.sv
module irq_vec_gen
   import irq_ctrl_pkg::*;
#(
   parameter int unsigned         NUM_SRC    = 8,
   parameter int unsigned         ADDR_W     = 16,
   parameter logic [ADDR_W-1:0]   VEC_BASE   = 16'h0003,
   parameter int unsigned         VEC_STRIDE = 8,
   localparam int unsigned        IDX_W      = $clog2(NUM_SRC),
   localparam int unsigned        SHIFT      = $clog2(VEC_STRIDE)
) (
   input  logic [IDX_W-1:0]  idx,
   input  logic              valid,
   output logic [ADDR_W-1:0] vec_addr
);

   logic [31:0] full;

   assign full     = entry_of(32'(VEC_BASE), 32'(idx), SHIFT);
   assign vec_addr = valid ? full[ADDR_W-1:0] : '0;

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
   import irq_ctrl_pkg::*;
#(
   parameter int unsigned         NUM_SRC    = 8,
   parameter int unsigned         ADDR_W     = 16,
   parameter logic [ADDR_W-1:0]   VEC_BASE   = 16'h0003,
   parameter int unsigned         VEC_STRIDE = 8,
   parameter logic [NUM_SRC-1:0]  DUAL_MASK  = 8'h60,
   localparam int unsigned        IDX_W      = $clog2(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_req,
   input  logic [NUM_SRC-1:0] irq_req_alt,
   input  logic               glob_en,
   input  logic [NUM_SRC-1:0] src_en,
   input  logic [NUM_SRC-1:0] src_hi,
   input  logic               insn_done,
   input  logic               reti,
   output logic               take,
   output logic [ADDR_W-1:0]  vec_addr,
   output logic [NUM_SRC-1:0] ack
);

   // Elaboration-time parameter checks
   if (NUM_SRC < 2 || NUM_SRC > 32) begin : g_bad_num
      $error("vec_irq_ctrl: NUM_SRC must lie in 2..32");
   end
   if (VEC_STRIDE == 0 || (VEC_STRIDE & (VEC_STRIDE - 1)) != 0) begin : g_bad_stride
      $error("vec_irq_ctrl: VEC_STRIDE must be a power of two");
   end
   if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
      $error("vec_irq_ctrl: ADDR_W must lie in 8..32");
   end
   if ((64'(VEC_BASE) + 64'(NUM_SRC - 1) * 64'(VEC_STRIDE)) >= (64'd1 << ADDR_W)) begin : g_bad_span
      $error("vec_irq_ctrl: entry table exceeds address width");
   end

   logic [NUM_SRC-1:0] cand_hi, cand_lo;
   logic               hi_any, lo_any;
   logic [IDX_W-1:0]   hi_idx, lo_idx, sel_idx;
   logic [NUM_SRC-1:0] hi_oh, lo_oh;
   logic               isv_hi, isv_lo, hold;
   logic               hi_ok, lo_ok, slot_open;
   lvl_e               sel_lvl;

   irq_src_cond #(
      .NUM_SRC   (NUM_SRC),
      .DUAL_MASK (DUAL_MASK)
   ) u_cond (
      .irq_req     (irq_req),
      .irq_req_alt (irq_req_alt),
      .glob_en     (glob_en),
      .src_en      (src_en),
      .src_hi      (src_hi),
      .cand_hi     (cand_hi),
      .cand_lo     (cand_lo)
   );

   irq_first_pick #(.NUM_SRC(NUM_SRC)) u_pick_hi (
      .cand   (cand_hi),
      .any    (hi_any),
      .idx    (hi_idx),
      .onehot (hi_oh)
   );

   irq_first_pick #(.NUM_SRC(NUM_SRC)) u_pick_lo (
      .cand   (cand_lo),
      .any    (lo_any),
      .idx    (lo_idx),
      .onehot (lo_oh)
   );

   // Preemption rule: high level blocked only by high in service,
   // low level blocked by either level in service.
   assign hi_ok     = hi_any & ~isv_hi;
   assign lo_ok     = lo_any & ~isv_hi & ~isv_lo;
   assign slot_open = rst_n & insn_done & ~reti & ~hold;

   assign take    = slot_open & (hi_ok | lo_ok);
   assign sel_lvl = hi_ok ? LVL_HI : LVL_LO;
   assign sel_idx = hi_ok ? hi_idx : lo_idx;
   assign ack     = take ? (hi_ok ? hi_oh : lo_oh) : '0;

   irq_level_track u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (take),
      .take_lvl  (sel_lvl),
      .reti      (reti),
      .insn_done (insn_done),
      .isv_hi    (isv_hi),
      .isv_lo    (isv_lo),
      .hold      (hold)
   );

   irq_vec_gen #(
      .NUM_SRC    (NUM_SRC),
      .ADDR_W     (ADDR_W),
      .VEC_BASE   (VEC_BASE),
      .VEC_STRIDE (VEC_STRIDE)
   ) u_vec (
      .idx      (sel_idx),
      .valid    (take),
      .vec_addr (vec_addr)
   );

endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk #(
   parameter int unsigned NUM_SRC = 8,
   parameter int unsigned ADDR_W  = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               glob_en,
   input logic               insn_done,
   input logic               reti,
   input logic               take,
   input logic [ADDR_W-1:0]  vec_addr,
   input logic [NUM_SRC-1:0] ack,
   input logic               isv_hi,
   input logic               isv_lo,
   input logic               take_hi
);

   logic shadow_hold;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow_hold <= 1'b0;
      end else if (reti) begin
         shadow_hold <= 1'b1;
      end else if (insn_done) begin
         shadow_hold <= 1'b0;
      end
   end

   // R1
   always_comb begin
      if (rst_n == 1'b0) begin
         rst_quiet_chk: assert (!take && ack == '0 && vec_addr == '0);
      end
   end

   // R2
   take_needs_glob_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> glob_en);

   // R3
   take_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> insn_done);

   // R4
   vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !take |-> vec_addr == '0);

   // R7
   low_take_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !take_hi) |-> (!isv_lo && !isv_hi));

   // R7
   high_take_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && take_hi) |-> !isv_hi);

   // R9
   reti_clear_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reti && isv_hi) |=> (!isv_hi && isv_lo == $past(isv_lo)));

   // R9
   reti_clear_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reti && !isv_hi) |=> !isv_lo);

   // R10
   post_return_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reti || shadow_hold) |-> !take);

   // R11
   ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ack));

   // R11
   ack_with_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> $countones(ack) == 1);

   // R11
   ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !take |-> ack == '0);

endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(
   .NUM_SRC (NUM_SRC),
   .ADDR_W  (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .glob_en   (glob_en),
   .insn_done (insn_done),
   .reti      (reti),
   .take      (take),
   .vec_addr  (vec_addr),
   .ack       (ack),
   .isv_hi    (isv_hi),
   .isv_lo    (isv_lo),
   .take_hi   (sel_lvl == irq_ctrl_pkg::LVL_HI)
);

// File: tb/test_vec_irq_ctrl.sv
module test_vec_irq_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  irq_req = '0, irq_req_alt = '0, src_en = '0, src_hi = '0;
   logic        glob_en = 1'b0, insn_done = 1'b0, reti = 1'b0;
   logic        take;
   logic [15:0] vec_addr;
   logic [7:0]  ack;

   // staged inputs applied at the next drive edge
   logic [7:0]  n_req = '0, n_alt = '0, n_en = '0, n_hi = '0;
   logic        n_gen = 1'b0;

   int checks = 0;
   int errors = 0;
   bit done_all = 1'b0;

   typedef struct {
      bit    t;
      int    idx;
      string tag;
   } exp_t;
   exp_t sb[$];

   always #10 clk = ~clk;

   vec_irq_ctrl i_vec_irq_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .irq_req     (irq_req),
      .irq_req_alt (irq_req_alt),
      .glob_en     (glob_en),
      .src_en      (src_en),
      .src_hi      (src_hi),
      .insn_done   (insn_done),
      .reti        (reti),
      .take        (take),
      .vec_addr    (vec_addr),
      .ack         (ack)
   );

   task automatic cyc(input bit d, input bit r, input bit et, input int ei, input string tag);
      exp_t e;
      @(negedge clk);
      irq_req     = n_req;
      irq_req_alt = n_alt;
      src_en      = n_en;
      src_hi      = n_hi;
      glob_en     = n_gen;
      insn_done   = d;
      reti        = r;
      e.t = et; e.idx = ei; e.tag = tag;
      sb.push_back(e);
   endtask

   // return, then one instruction that must not take (R9, R10)
   task automatic ret_clear();
      cyc(1'b0, 1'b1, 1'b0, 0, "R9");
      cyc(1'b1, 1'b0, 1'b0, 0, "R10");
   endtask

   // monitor: compare outputs mid-way between drive edge and active edge
   initial begin
      forever begin
         @(negedge clk);
         #5;
         if (sb.size() > 0) begin
            exp_t e;
            logic [15:0] ev;
            logic [7:0]  ea;
            e  = sb.pop_front();
            ev = e.t ? 16'(3 + 8 * e.idx) : 16'h0000;
            ea = e.t ? 8'(1 << e.idx) : 8'h00;
            checks++;
            if (take !== e.t) begin
               errors++;
               $display("FAIL %s take: actual %0b expected %0b", e.tag, take, e.t);
            end
            if (vec_addr !== ev) begin
               errors++;
               $display("FAIL %s/R4 vec_addr: actual %h expected %h", e.tag, vec_addr, ev);
            end
            if (ack !== ea) begin
               errors++;
               $display("FAIL %s/R11 ack: actual %b expected %b", e.tag, ack, ea);
            end
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done_all) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1: reset holds outputs quiet even with everything requesting
      n_req = 8'hFF; n_en = 8'hFF; n_gen = 1'b1; n_hi = 8'h00;
      cyc(1'b1, 1'b0, 1'b0, 0, "R1");
      cyc(1'b1, 1'b0, 1'b0, 0, "R1");
      @(negedge clk);
      rst_n = 1'b1; insn_done = 1'b0; reti = 1'b0;

      // R2: global and per-source enable both needed
      n_req = 8'h04; n_gen = 1'b0; n_en = 8'hFF;
      cyc(1'b1, 1'b0, 1'b0, 0, "R2");
      n_gen = 1'b1; n_en = 8'hFB;
      cyc(1'b1, 1'b0, 1'b0, 0, "R2");
      n_en = 8'hFF;
      // R3: no take without instruction completion
      cyc(1'b0, 1'b0, 1'b0, 0, "R3");
      cyc(1'b1, 1'b0, 1'b1, 2, "R3");          // low level in service
      // R7: same level waits, high preempts, nothing over high
      cyc(1'b1, 1'b0, 1'b0, 0, "R7");
      n_hi = 8'h40; n_req = 8'h44;
      cyc(1'b1, 1'b0, 1'b1, 6, "R7");
      cyc(1'b1, 1'b0, 1'b0, 0, "R7");
      // R10: return with completion in same cycle, then one more blocked
      cyc(1'b1, 1'b1, 1'b0, 0, "R10");
      n_req = 8'h04;
      cyc(1'b1, 1'b0, 1'b0, 0, "R10");
      // R9: low level still in service after high returned
      cyc(1'b1, 1'b0, 1'b0, 0, "R9");
      cyc(1'b0, 1'b1, 1'b0, 0, "R9");
      cyc(1'b1, 1'b0, 1'b0, 0, "R10");
      cyc(1'b1, 1'b0, 1'b1, 2, "R9");
      n_req = 8'h00;
      ret_clear();

      // R5: tie within low level, lowest index wins
      n_hi = 8'h00; n_req = 8'hA0;
      cyc(1'b1, 1'b0, 1'b1, 5, "R5");
      n_req = 8'h00;
      ret_clear();

      // R6: high level beats lower index at low level
      n_hi = 8'h80; n_req = 8'h81;
      cyc(1'b1, 1'b0, 1'b1, 7, "R6");
      n_req = 8'h00;
      ret_clear();

      // R8: second flags only for sources 5 and 6
      n_hi = 8'h00; n_alt = 8'h9F;
      cyc(1'b1, 1'b0, 1'b0, 0, "R8");
      n_alt = 8'h40;
      cyc(1'b1, 1'b0, 1'b1, 6, "R8");
      n_alt = 8'h00;
      ret_clear();
      n_alt = 8'h20;
      cyc(1'b1, 1'b0, 1'b1, 5, "R8");
      n_alt = 8'h00;
      ret_clear();

      // R4: lowest entry address
      n_req = 8'h01;
      cyc(1'b1, 1'b0, 1'b1, 0, "R4");
      n_req = 8'h00;
      ret_clear();

      repeat (3) @(negedge clk);
      done_all = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule